// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds the priority byte of every interrupt handled by a distributor, together with one priority-mask byte for each CPU interface. Only the upper `PRIO_BITS` bits of each byte are real storage. The lower bits are forced to zero on every write and on every read. Software reaches the bank through a single-cycle request port. Each request carries an interrupt number, the index of the requesting CPU, a non-secure attribute and a select line that chooses between the interrupt priority field and the CPU's priority mask.

The first 32 interrupt numbers are private to each CPU, so the bank keeps one priority copy of each of them for every CPU, selected by the request's CPU index. Interrupts from 32 upward are shared, and every CPU sees the same copy. When security support is enabled, non-secure accesses to priority fields see a translated view: a write lands in the lower half of the priority range, and a read returns the stored value shifted up by one place.

A small access sequencer tracks what the previous cycle did. It has three states. `ST_IDLE` means no request was taken. `ST_WDONE` means a write was committed. `ST_RDONE` means read data is being presented. From every state, the next state is chosen by the current request: a read request leads to `ST_RDONE`, a write request leads to `ST_WDONE`, and no request leads to `ST_IDLE`.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset, every priority entry and every priority mask reads as 0x00, and `rd_valid` is low.
- R2: Each stored byte keeps only its upper `PRIO_BITS` bits (keep-mask = 0xFF shifted left by 8 − `PRIO_BITS`), so unimplemented low bits read as zero whatever was written (with `PRIO_BITS`=5 a write of 0xFF reads back as 0xF8 and a write of 0x07 reads back as 0x00). `PRIO_BITS` defaults to 8, and elaboration is refused outside the range 4 to 8.
- R3: A non-secure priority write with `SEC_EN`=1 stores (0x80 OR (data >> 1)) AND keep-mask. A secure write stores data AND keep-mask. With `SEC_EN`=0 every access is treated as secure.
- R4: A non-secure priority read with `SEC_EN`=1 returns ((stored << 1) AND 0xFF) AND keep-mask. A secure read returns the stored value unchanged.
- R5: A read request (`req_valid`=1, `req_write`=0) makes `rd_valid` high with `rd_data` in the next cycle. `rd_valid` is low in a cycle that follows a write or no request. Reads on consecutive cycles each return their own data.
- R6: For interrupt numbers below 32, each CPU index has its own priority copy. For numbers from 32 to `NUM_IRQ`−1, all CPU indices access one shared copy.
- R7: With `req_pmask`=1 the request addresses the mask of CPU `req_cpu`, and `req_irq` is ignored. The written value is reduced by the keep-mask without any non-secure translation. A read returns the stored mask.
- R8: A request with `req_irq` ≥ `NUM_IRQ`, or with `req_cpu` ≥ `NUM_CPU`, changes no register, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request taken in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_pmask | input | 1 | 1 = CPU priority mask, 0 = interrupt priority field |
| req_irq | input | IRQ_W | Interrupt number |
| req_cpu | input | CPU_W | Requesting CPU index |
| req_nonsec | input | 1 | 1 = non-secure access |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Registered read byte |

## Verification
A corrupted or misrouted stored byte can only appear at the ports as a wrong `rd_data`. It shows in the cycle right after a read of the affected entry, so the bench reads every entry back, for every CPU copy, after each write sweep. A banking fault shows as one CPU's value appearing in another CPU's read. A bad translation shows as a wrong top bit or low bit in a non-secure read. A wrong sequencer state shows within one cycle as `rd_valid` high after a write or an idle cycle, or low after a read.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int PRIO_W     = 8;
    localparam int LOCAL_IRQS = 32;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDONE = 2'd1,
        ST_RDONE = 2'd2
    } acc_state_e;

    // Upper 'bits' bits set, the rest clear.
    function automatic prio_t keep_mask(input int bits);
        return prio_t'(8'hFF << (PRIO_W - bits));
    endfunction

    // Non-secure write view: pushed into the lower half of the range.
    function automatic prio_t ns_to_store(input prio_t v);
        return 8'h80 | {1'b0, v[7:1]};
    endfunction

    // Non-secure read view: stored value moved up one place.
    function automatic prio_t store_to_ns(input prio_t v);
        return {v[6:0], 1'b0};
    endfunction

endpackage

// File: rtl/prio_xlate.sv
module prio_xlate
    import prio_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    parameter bit SEC_EN    = 1'b1
) (
    input  logic  nonsec,
    input  prio_t wdata,
    input  prio_t stored,
    output prio_t prio_wr,
    output prio_t prio_rd,
    output prio_t pmask_wr
);

    localparam prio_t KEEP = keep_mask(PRIO_BITS);

    logic ns_eff;

    always_comb begin
        ns_eff   = SEC_EN && nonsec;
        prio_wr  = (ns_eff ? ns_to_store(wdata) : wdata) & KEEP;
        prio_rd  = (ns_eff ? store_to_ns(stored) : stored) & KEEP;
        pmask_wr = wdata & KEEP;
    end

endmodule

// File: rtl/prio_store.sv
module prio_store
    import prio_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_IRQ = 64,
    parameter int IRQ_W   = 6,
    parameter int CPU_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IRQ_W-1:0] irq,
    input  logic [CPU_W-1:0] cpu,
    input  prio_t            wdata,
    output prio_t            rdata
);

    localparam int NUM_SHARED = NUM_IRQ - LOCAL_IRQS;
    localparam int LOC_W      = $clog2(LOCAL_IRQS);
    localparam int SH_W       = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

    logic             in_range;
    logic             is_local;
    logic             cpu_ok;
    logic [LOC_W-1:0] li;
    logic [SH_W-1:0]  si;

    logic [NUM_CPU-1:0][PRIO_W-1:0] cpu_rd;
    prio_t                          shared_q [NUM_SHARED];

    always_comb begin
        in_range = ({1'b0, irq} < (IRQ_W+1)'(NUM_IRQ));
        is_local = (irq < IRQ_W'(LOCAL_IRQS));
        cpu_ok   = ({1'b0, cpu} < (CPU_W+1)'(NUM_CPU));
        li       = irq[LOC_W-1:0];
        si       = SH_W'(irq - IRQ_W'(LOCAL_IRQS));
    end

    // One private bank of priorities per CPU
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_bank
        prio_t bank_q [LOCAL_IRQS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < LOCAL_IRQS; i++) begin
                    bank_q[i] <= '0;
                end
            end else if (we && cpu_ok && is_local && (cpu == CPU_W'(c))) begin
                bank_q[li] <= wdata;
            end
        end

        assign cpu_rd[c] = bank_q[li];
    end

    // Shared priorities
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SHARED; i++) begin
                shared_q[i] <= '0;
            end
        end else if (we && cpu_ok && in_range && !is_local) begin
            shared_q[si] <= wdata;
        end
    end

    always_comb begin
        if (!in_range || !cpu_ok) begin
            rdata = '0;
        end else if (is_local) begin
            rdata = cpu_rd[cpu];
        end else begin
            rdata = shared_q[si];
        end
    end

endmodule

// File: rtl/prio_mask_regs.sv
module prio_mask_regs
    import prio_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CPU_W-1:0] cpu,
    input  prio_t            wdata,
    output prio_t            rdata
);

    logic                           cpu_ok;
    logic [NUM_CPU-1:0][PRIO_W-1:0] mask_q;

    assign cpu_ok = ({1'b0, cpu} < (CPU_W+1)'(NUM_CPU));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[c] <= '0;
            end else if (we && cpu_ok && (cpu == CPU_W'(c))) begin
                mask_q[c] <= wdata;
            end
        end
    end

    assign rdata = cpu_ok ? mask_q[cpu] : '0;

endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
    import prio_pkg::*;
#(
    parameter  int PRIO_BITS = 8,
    parameter  int NUM_CPU   = 4,
    parameter  int NUM_IRQ   = 64,
    parameter  bit SEC_EN    = 1'b1,
    localparam int IRQ_W     = $clog2(NUM_IRQ),
    localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_pmask,
    input  logic [IRQ_W-1:0] req_irq,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic             req_nonsec,
    input  logic [7:0]       req_wdata,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);

    // Elaboration-time range checks (R2)
    if (PRIO_BITS < 4 || PRIO_BITS > PRIO_W) begin : g_bad_prio_bits
        $fatal(1, "PRIO_BITS must lie between 4 and 8");
    end
    if (NUM_IRQ <= LOCAL_IRQS) begin : g_bad_num_irq
        $fatal(1, "NUM_IRQ must exceed the private interrupt count");
    end
    if (NUM_CPU < 1) begin : g_bad_num_cpu
        $fatal(1, "NUM_CPU must be at least 1");
    end

    acc_state_e state_q;
    acc_state_e state_d;

    logic  rd_req;
    logic  wr_prio;
    logic  wr_mask;
    prio_t stored_prio;
    prio_t prio_wr;
    prio_t prio_view;
    prio_t mask_wr;
    prio_t mask_rd;

    always_comb begin
        rd_req  = req_valid && !req_write;
        wr_prio = req_valid && req_write && !req_pmask;
        wr_mask = req_valid && req_write && req_pmask;
    end

    prio_xlate #(
        .PRIO_BITS (PRIO_BITS),
        .SEC_EN    (SEC_EN)
    ) xlate_i (
        .nonsec   (req_nonsec),
        .wdata    (req_wdata),
        .stored   (stored_prio),
        .prio_wr  (prio_wr),
        .prio_rd  (prio_view),
        .pmask_wr (mask_wr)
    );

    prio_store #(
        .NUM_CPU (NUM_CPU),
        .NUM_IRQ (NUM_IRQ),
        .IRQ_W   (IRQ_W),
        .CPU_W   (CPU_W)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_prio),
        .irq   (req_irq),
        .cpu   (req_cpu),
        .wdata (prio_wr),
        .rdata (stored_prio)
    );

    prio_mask_regs #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) mask_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_mask),
        .cpu   (req_cpu),
        .wdata (mask_wr),
        .rdata (mask_rd)
    );

    // Access sequencer: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WDONE, ST_RDONE: begin
                if (rd_req) begin
                    state_d = ST_RDONE;
                end else if (req_valid) begin
                    state_d = ST_WDONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= req_pmask ? mask_rd : prio_view;
        end
    end

    assign rd_valid = (state_q == ST_RDONE);

endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
    parameter int PRIO_BITS = 8,
    parameter int NUM_IRQ   = 64,
    parameter bit SEC_EN    = 1'b1,
    parameter int IRQ_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             req_pmask,
    input logic [IRQ_W-1:0] req_irq,
    input logic             req_nonsec,
    input logic             rd_valid,
    input logic [7:0]       rd_data
);

    localparam logic [7:0] KEEP = 8'(8'hFF << (8 - PRIO_BITS));

    logic rd_req;
    logic oor_irq;

    assign rd_req  = req_valid && !req_write;
    assign oor_irq = ({1'b0, req_irq} >= (IRQ_W+1)'(NUM_IRQ));

    // R5: a read yields valid data in the next cycle
    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R5: no valid data after a write or an idle cycle
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    // R2: unimplemented low bits never appear
    a_r2_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~KEEP) == 8'h00));

    // R4: translated non-secure read has a clear bit 0
    a_r4_ns_read_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (SEC_EN && rd_req && !req_pmask && req_nonsec) |=> (rd_data[0] == 1'b0));

    // R8: out-of-range interrupt reads as zero
    a_r8_oor_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !req_pmask && oor_irq) |=> (rd_data == 8'h00));

    // R1: quiet output while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!rd_valid);
        end
    end

endmodule

bind irq_prio_bank prio_bank_chk #(
    .PRIO_BITS (PRIO_BITS),
    .NUM_IRQ   (NUM_IRQ),
    .SEC_EN    (SEC_EN),
    .IRQ_W     (IRQ_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_pmask  (req_pmask),
    .req_irq    (req_irq),
    .req_nonsec (req_nonsec),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/irq_prio_bank_tb_top.sv
module irq_prio_bank_tb_top;

    localparam int PB   = 5;
    localparam int NCPU = 3;
    localparam int NIRQ = 40;
    localparam int IW   = 6;
    localparam int CW   = 2;
    localparam logic [7:0] K = 8'(8'hFF << (8 - PB));

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_pmask = 1'b0;
    logic [IW-1:0] req_irq = '0;
    logic [CW-1:0] req_cpu = '0;
    logic          req_nonsec = 1'b0;
    logic [7:0]    req_wdata = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [7:0] m_loc [NCPU][32];
    logic [7:0] m_sh  [NIRQ-32];
    logic [7:0] m_pm  [NCPU];

    always #5 clk = ~clk;

    irq_prio_bank #(
        .PRIO_BITS (PB),
        .NUM_CPU   (NCPU),
        .NUM_IRQ   (NIRQ),
        .SEC_EN    (1'b1)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_pmask  (req_pmask),
        .req_irq    (req_irq),
        .req_cpu    (req_cpu),
        .req_nonsec (req_nonsec),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input bit pm, input int irq, input int cpu, input bit ns);
        logic [7:0] s;
        if (cpu >= NCPU) return 8'h00;
        if (pm) return m_pm[cpu];
        if (irq >= NIRQ) return 8'h00;
        s = (irq < 32) ? m_loc[cpu][irq] : m_sh[irq-32];
        return ns ? (8'(s << 1) & K) : s;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_wr(input bit pm, input int irq, input int cpu, input bit ns, input logic [7:0] d);
        logic [7:0] v;
        req_valid = 1'b1; req_write = 1'b1; req_pmask = pm;
        req_irq = IW'(irq); req_cpu = CW'(cpu); req_nonsec = ns; req_wdata = d;
        @(posedge clk); #1;
        chk("R5 no valid after write", {7'd0, rd_valid}, 8'h00);
        if (cpu < NCPU) begin
            if (pm) begin
                m_pm[cpu] = d & K;
            end else if (irq < NIRQ) begin
                v = ns ? (8'h80 | (d >> 1)) : d;
                v = v & K;
                if (irq < 32) m_loc[cpu][irq] = v;
                else          m_sh[irq-32] = v;
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_rd(input bit pm, input int irq, input int cpu, input bit ns, input string tag);
        req_valid = 1'b1; req_write = 1'b0; req_pmask = pm;
        req_irq = IW'(irq); req_cpu = CW'(cpu); req_nonsec = ns;
        @(posedge clk); #1;
        chk({tag, " valid"}, {7'd0, rd_valid}, 8'h01);
        chk(tag, rd_data, exp_read(pm, irq, cpu, ns));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sweep_rd(input bit ns, input string tag);
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NIRQ; i++) begin
                do_rd(1'b0, i, c, ns, tag);
            end
        end
    endtask

    initial begin
        for (int c = 0; c < NCPU; c++) begin
            m_pm[c] = 8'h00;
            for (int i = 0; i < 32; i++) m_loc[c][i] = 8'h00;
        end
        for (int i = 0; i < NIRQ - 32; i++) m_sh[i] = 8'h00;

        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything zero after reset
        sweep_rd(1'b0, "R1 reset priority");
        for (int c = 0; c < NCPU; c++) do_rd(1'b1, 0, c, 1'b0, "R1 reset mask");

        // R6 / R2: distinct secure values per CPU; shared entries end with last CPU
        for (int c = 0; c < NCPU; c++) begin
            for (int i = 0; i < NIRQ; i++) begin
                do_wr(1'b0, i, c, 1'b0, 8'((i * 37 + c * 91 + 5) & 255));
            end
        end
        sweep_rd(1'b0, "R6 banked/shared secure read");
        sweep_rd(1'b1, "R4 non-secure read view");

        // R2: explicit truncation corners
        do_wr(1'b0, 35, 0, 1'b0, 8'hFF);
        do_rd(1'b0, 35, 2, 1'b0, "R2 write FF");
        chk("R2 FF literal", rd_data, 8'hF8);
        @(negedge clk);
        do_wr(1'b0, 7, 1, 1'b0, 8'h07);
        do_rd(1'b0, 7, 1, 1'b0, "R2 write 07");
        chk("R2 07 literal", rd_data, 8'h00);
        @(negedge clk);

        // R3 / R4: non-secure writes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            d = 8'((k * 73 + 1) & 255);
            do_wr(1'b0, 33, k % NCPU, 1'b1, d);
            do_rd(1'b0, 33, 0, 1'b0, "R3 ns write secure read");
            do_rd(1'b0, 33, 1, 1'b1, "R4 ns write ns read");
            do_wr(1'b0, k, 2, 1'b1, d);
            do_rd(1'b0, k, 2, 1'b0, "R3 ns write local");
        end
        do_wr(1'b0, 34, 0, 1'b1, 8'h00);
        do_rd(1'b0, 34, 0, 1'b0, "R3 ns write 00");
        chk("R3 ns 00 literal", rd_data, 8'h80);
        @(negedge clk);

        // R7: priority masks, no translation, irq ignored
        for (int c = 0; c < NCPU; c++) begin
            do_wr(1'b1, 63 - c, c, 1'b1, 8'(8'hE7 ^ (c * 8'h21)));
        end
        for (int c = 0; c < NCPU; c++) begin
            do_rd(1'b1, c, c, 1'b1, "R7 mask readback");
        end
        sweep_rd(1'b0, "R7 masks left priorities alone");

        // R8: out-of-range interrupt and CPU
        do_wr(1'b0, 50, 0, 1'b0, 8'hA8);
        do_wr(1'b0, 5, 3, 1'b0, 8'hC0);
        do_wr(1'b0, 36, 3, 1'b0, 8'hC0);
        do_wr(1'b1, 0, 3, 1'b0, 8'hC0);
        do_rd(1'b0, 50, 0, 1'b0, "R8 oor irq read");
        do_rd(1'b0, 5, 3, 1'b0, "R8 oor cpu read");
        do_rd(1'b1, 0, 3, 1'b0, "R8 oor cpu mask read");
        sweep_rd(1'b0, "R8 state untouched");
        for (int c = 0; c < NCPU; c++) do_rd(1'b1, 0, c, 1'b0, "R8 masks untouched");

        // R5: valid drops after an idle cycle
        do_rd(1'b0, 3, 0, 1'b0, "R5 single read");
        @(posedge clk); #1;
        chk("R5 idle after read", {7'd0, rd_valid}, 8'h00);
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule